// File: doc/BRIEF.md
# Write-Strobe Qualifier with Supply-Settle Inhibit

This block guards the write path of a memory. It takes the raw active-low chip-select and write-enable strobes, the active-low output enable and a digital supply-good flag from an external comparator. It returns cleaned copies of the two strobes and a single write-permission signal. A strobe only reaches its output after staying low for a programmable number of clock samples, so short glitches never turn into a write. The strobe is released on the first sample that sees it high again.

Write permission needs three things at once. The supply flag must be high now. The flag must also have been sampled high without a break for a programmable settling time, so a supply that has just come up cannot start a write. Output enable must be high. When the supply flag or output enable falls, permission drops in the same cycle. A drop of the supply flag also restarts the whole settling time.

Both widths are counted in clock cycles. All logic runs on one clock with an asynchronous active-low reset whose release is synchronised inside the block. Internal state leaves reset on the third rising edge after the reset input goes high.

Top module: `wr_strobe_guard`

## Requirements
- R1: While `vdd_ok_in` is 0, `wr_allow` is 0 in that same cycle, with no clock edge needed.
- R2: `wr_allow` is 1 only after `vdd_ok_in` has been sampled 1 on `SETTLE_CYC` consecutive rising edges. It becomes 1 right after the edge that takes the `SETTLE_CYC`-th such sample, provided `oe_n_in` is 1.
- R3: One rising edge that samples `vdd_ok_in` as 0 clears the settling run. Permission then returns only after another full `SETTLE_CYC` consecutive high samples.
- R4: While `oe_n_in` is 0, `wr_allow` is 0 in that same cycle, whatever the state of the strobes or the supply.
- R5: `cs_n_out` goes to 0 only after `cs_n_in` has been sampled 0 on `GLITCH_CYC` consecutive rising edges. A low pulse that covers fewer samples never appears at the output.
- R6: `we_n_out` follows the same minimum-width rule as R5, applied to `we_n_in`.
- R7: A cleaned strobe returns to 1 right after the first rising edge that samples its raw input as 1.
- R8: During reset, `cs_n_out` and `we_n_out` are 1 and `wr_allow` is 0, even when the raw strobes are held low.
- R9: The two strobes are filtered independently. Activity on one never shortens, lengthens or passes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Raw chip select, active low |
| we_n_in | input | 1 | Raw write enable, active low |
| oe_n_in | input | 1 | Output enable, active low; when low, writes are inhibited |
| vdd_ok_in | input | 1 | Supply above threshold, from an external comparator |
| cs_n_out | output | 1 | Glitch-filtered chip select, active low |
| we_n_out | output | 1 | Glitch-filtered write enable, active low |
| wr_allow | output | 1 | Write permission |

## Verification
The bench drives low pulses exactly one sample short of the filter width and exactly at the width. A filter that is off by one either passes the short pulse as a spurious write or holds back a legal strobe for an extra cycle. Permission is checked on the edge before and the edge of the last settling sample, and again after a single-cycle supply dropout. A timer that only pauses on a dropout, instead of restarting, would grant permission too early there. Output enable and supply drops are checked in the same cycle they occur, which catches a permission path that waits for a register. One strobe is toggled while the other is held low, which catches filters that share a counter. A random phase compares every output with a behavioural model on every cycle.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  // Index of each filtered strobe in the internal strobe vectors
  typedef enum int {
    STB_CS = 0,
    STB_WE = 1
  } stb_idx_e;

  localparam int NUM_STB = 2;

  // Counter width able to hold values 0..limit
  function automatic int run_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/wsg_reset_sync.sv
module wsg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/wsg_run_detect.sv
// Counts consecutive samples of level_hit == 1, saturating at RUN_LEN.
// reached goes high on the edge of the RUN_LEN-th sample and low on the
// first sample of level_hit == 0.
module wsg_run_detect #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_hit,
  output logic reached
);
  import wsg_pkg::*;

  localparam int CW = run_width(RUN_LEN);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          reached_q, reached_d;

  always_comb begin
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    if (!level_hit) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != LIMIT) begin
      cnt_d  = cnt_q + CW'(1);
      cnt_en = 1'b1;
    end
    reached_d = level_hit && (cnt_d == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      reached_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      reached_q <= reached_d;
    end
  end

  assign reached = reached_q;
endmodule

// File: rtl/wsg_permit_gate.sv
module wsg_permit_gate (
  input  logic settled,
  input  logic vdd_ok,
  input  logic oe_n,
  output logic allow
);
  // Live supply flag and output enable act without waiting for a clock edge
  always_comb allow = settled && vdd_ok && oe_n;
endmodule

// File: rtl/wr_strobe_guard.sv
module wr_strobe_guard #(
  parameter int GLITCH_CYC  = 4,
  parameter int SETTLE_CYC  = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_in,
  input  logic we_n_in,
  input  logic oe_n_in,
  input  logic vdd_ok_in,
  output logic cs_n_out,
  output logic we_n_out,
  output logic wr_allow
);
  import wsg_pkg::*;

  logic               rst_n_int;
  logic [NUM_STB-1:0] raw_n;
  logic [NUM_STB-1:0] held_low;
  logic               settled;

  wsg_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  assign raw_n[STB_CS] = cs_n_in;
  assign raw_n[STB_WE] = we_n_in;

  for (genvar i = 0; i < NUM_STB; i++) begin : g_filt
    wsg_run_detect #(.RUN_LEN(GLITCH_CYC)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .level_hit(!raw_n[i]),
      .reached  (held_low[i])
    );
  end

  assign cs_n_out = !held_low[STB_CS];
  assign we_n_out = !held_low[STB_WE];

  wsg_run_detect #(.RUN_LEN(SETTLE_CYC)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .level_hit(vdd_ok_in),
    .reached  (settled)
  );

  wsg_permit_gate u_gate (
    .settled(settled),
    .vdd_ok (vdd_ok_in),
    .oe_n   (oe_n_in),
    .allow  (wr_allow)
  );
endmodule

// File: rtl/wsg_guard_chk.sv
module wsg_guard_chk #(
  parameter int GLITCH_CYC = 4,
  parameter int SETTLE_CYC = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_in,
  input logic we_n_in,
  input logic oe_n_in,
  input logic vdd_ok_in,
  input logic cs_n_out,
  input logic we_n_out,
  input logic wr_allow
);
  // Run lengths observed at the ports, saturating at the checked limit
  int unsigned cs_run, we_run, vdd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_run  <= 0;
      we_run  <= 0;
      vdd_run <= 0;
    end else begin
      if (cs_n_in) cs_run <= 0;
      else if (cs_run < GLITCH_CYC) cs_run <= cs_run + 1;
      if (we_n_in) we_run <= 0;
      else if (we_run < GLITCH_CYC) we_run <= we_run + 1;
      if (!vdd_ok_in) vdd_run <= 0;
      else if (vdd_run < SETTLE_CYC) vdd_run <= vdd_run + 1;
    end
  end

  a_r1_no_supply_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_ok_in |-> !wr_allow);

  a_r2_settle_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> (vdd_run >= SETTLE_CYC));

  a_r4_oe_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_in |-> !wr_allow);

  a_r5_cs_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_out |-> (cs_run >= GLITCH_CYC));

  a_r6_we_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_out |-> (we_run >= GLITCH_CYC));

  a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_in |=> cs_n_out);

  a_r7_we_release: assert property (@(posedge clk) disable iff (!rst_n)
    we_n_in |=> we_n_out);
endmodule

bind wr_strobe_guard wsg_guard_chk #(
  .GLITCH_CYC(GLITCH_CYC),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (.*);

// File: tb/wr_strobe_guard_test.sv
module wr_strobe_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int S = 20;

  logic clk = 1'b0;
  logic rst_n, cs_n_in, we_n_in, oe_n_in, vdd_ok_in;
  logic cs_n_out, we_n_out, wr_allow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_strobe_guard #(.GLITCH_CYC(G), .SETTLE_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .we_n_in(we_n_in),
    .oe_n_in(oe_n_in), .vdd_ok_in(vdd_ok_in),
    .cs_n_out(cs_n_out), .we_n_out(we_n_out), .wr_allow(wr_allow)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Behavioural reference: run lengths counted from the port samples
  int rs = 0, rc = 0, rw = 0, rv = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      rs = 0; rc = 0; rw = 0; rv = 0;
    end else begin
      if (rs < 10) rs++;
      if (rs >= 3) begin
        rc = cs_n_in   ? 0 : (rc < 1000 ? rc + 1 : rc);
        rw = we_n_in   ? 0 : (rw < 1000 ? rw + 1 : rw);
        rv = !vdd_ok_in ? 0 : (rv < 1000 ? rv + 1 : rv);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R5 cs_n_out model", cs_n_out, !(rc >= G));
      chk("R6 we_n_out model", we_n_out, !(rw >= G));
      chk("R2 wr_allow model", wr_allow, (rv >= S) && vdd_ok_in && oe_n_in);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n_in = 1'b0; we_n_in = 1'b0; oe_n_in = 1'b1; vdd_ok_in = 1'b1;
    repeat (4) tick();
    @(negedge clk);
    chk("R8 cs_n_out in reset", cs_n_out, 1'b1);
    chk("R8 we_n_out in reset", we_n_out, 1'b1);
    chk("R8 wr_allow in reset", wr_allow, 1'b0);
    tick();
    cs_n_in = 1'b1; we_n_in = 1'b1; vdd_ok_in = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (6) tick();
    @(negedge clk);
    chk("R1 no permit with supply low", wr_allow, 1'b0);

    // R2: settle window
    tick();
    vdd_ok_in = 1'b1;
    repeat (S - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 one sample short", wr_allow, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 settled", wr_allow, 1'b1);

    // R4: output enable inhibit, same cycle
    tick();
    oe_n_in = 1'b0;
    @(negedge clk);
    chk("R4 oe low blocks", wr_allow, 1'b0);
    tick();
    oe_n_in = 1'b1;
    @(negedge clk);
    chk("R4 oe high restores", wr_allow, 1'b1);

    // R5: pulse one sample short
    tick(); cs_n_in = 1'b0;
    tick(); tick(); tick();
    cs_n_in = 1'b1;
    @(negedge clk);
    chk("R5 short pulse blocked", cs_n_out, 1'b1);
    tick();
    @(negedge clk);
    chk("R5 short pulse never seen", cs_n_out, 1'b1);

    // R5: pulse of exactly G samples
    tick(); cs_n_in = 1'b0;
    repeat (G - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 before width", cs_n_out, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R5 at width", cs_n_out, 1'b0);
    chk("R9 we untouched by cs", we_n_out, 1'b1);

    // R7: release on first high sample
    tick(); cs_n_in = 1'b1;
    @(negedge clk);
    chk("R7 held until sampled high", cs_n_out, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 cs released", cs_n_out, 1'b1);

    // R6 and R9: we held low while cs toggles
    tick(); we_n_in = 1'b0; cs_n_in = 1'b0;
    tick(); cs_n_in = 1'b1;
    tick(); cs_n_in = 1'b0;
    tick(); cs_n_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R6 we passes at width", we_n_out, 1'b0);
    chk("R9 toggling cs not passed", cs_n_out, 1'b1);
    tick(); we_n_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 we released", we_n_out, 1'b1);

    // R1 and R3: single-cycle supply dropout
    tick(); vdd_ok_in = 1'b0;
    @(negedge clk);
    chk("R1 drop blocks same cycle", wr_allow, 1'b0);
    tick(); vdd_ok_in = 1'b1;
    repeat (S - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 full window again, one short", wr_allow, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 full window again", wr_allow, 1'b1);

    // Random phase checked by the per-cycle model
    for (int i = 0; i < 3000; i++) begin
      tick();
      if ($urandom_range(0, 3) == 0) cs_n_in = ~cs_n_in;
      if ($urandom_range(0, 3) == 0) we_n_in = ~we_n_in;
      if ($urandom_range(0, 7) == 0) oe_n_in = ~oe_n_in;
      if ($urandom_range(0, 39) == 0) vdd_ok_in = ~vdd_ok_in;
      else if (!vdd_ok_in && $urandom_range(0, 2) == 0) vdd_ok_in = 1'b1;
    end

    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule